// File: doc/BRIEF.md
# Row-Bypassing Carry-Save Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It is purely combinational. The structure is a carry-save array: an AND-gate matrix forms the partial products, one carry-save row folds in each multiplier bit above bit 0, and a ripple-carry adder merges the final sum and carry vectors into the upper half of the product.

To save switching power, every carry-save row whose multiplier bit is zero is skipped. Inside a skipped row the adder inputs are forced to zero, so the idle cells do not toggle. The sum and carry vectors from the row above pass through to the row below. The rightmost column of a skipped row still has to yield one product bit. A half-adder correction cell produces that bit, and its carry is added back into the passed sum vector by a small incrementer chain.

The block is used wherever a low-activity unsigned multiply is needed and no register stage is wanted. The operand width is set by the parameter N, which supports values from 4 to 8.

Top module: `bypass_array_mult`

## Requirements
- R1: For every pair of unsigned inputs, `prod` equals `mcand * mplier` in full 2N-bit width, and the final merge adder never carries out of bit 2N-1.
- R2: When either operand is zero, `prod` is zero on every bit.
- R3: When `mplier` equals 1, so that only bit 0 is set and every row above it is skipped, `prod` equals `mcand` zero-extended.
- R4: When `mplier` has all N bits set, so that no row is skipped, `prod` equals `mcand * (2^N - 1)`. For example, 15 * 15 gives 225 at N=4.
- R5: For each row j from 1 to N-1, when `mplier[j]` is 0, every adder input of that row (partial products, incoming sum, incoming carry) is held at zero.
- R6: Multiplier patterns that alternate skipped and active rows, such as 0101 and 1010 at N=4, give the exact product. This holds even when the correction carry of a skipped row is nonzero.
- R7: `prod[0]` equals `mcand[0] & mplier[0]`.
- R8: The block holds no state. `prod` settles to the new product after any change of the inputs, without any clock edge.
- R9: The same RTL gives exact products with N set to 6 (checked on every input pair) and with N set to 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | N | Unsigned multiplicand |
| mplier | input | N | Unsigned multiplier; bit j (j ≥ 1) enables carry-save row j |
| prod | output | 2N | Unsigned product |

## Verification
Two functions can act on the same column at once. One is the correction cell of a skipped row, which resolves that row's rightmost column and feeds its carry into the passed sum vector. The other is the full-adder work of the next active row, which consumes that vector. The bench provokes this with all-ones multiplicands against alternating multiplier bits, and the exhaustive sweeps at N=4 and N=6 cover every other overlap. Each product is judged against a behavioural multiply computed in the bench. A checker also confirms that the adder inputs of each skipped row stay at zero.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

    function automatic logic fa_sum(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

    function automatic logic fa_cout(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/rbm_first_row.sv
module rbm_first_row #(
    parameter int N = 4
) (
    input  logic [N-1:0] mcand,
    input  logic         mbit,
    output logic         p_bit,
    output logic [N-1:0] sum_q,
    output logic [N-1:0] cry_q
);
    logic [N-1:0] pp_d;

    assign pp_d  = mcand & {N{mbit}};
    assign p_bit = pp_d[0];
    // Remaining partial products move one column right for the next row.
    assign sum_q = {1'b0, pp_d[N-1:1]};
    assign cry_q = '0;
endmodule

// File: rtl/rbm_csa_row.sv
module rbm_csa_row #(
    parameter int N    = 4,
    parameter bit HALF = 1'b0
) (
    input  logic [N-1:0] mcand,
    input  logic         sel,
    input  logic [N-1:0] sum_in,
    input  logic [N-1:0] cry_in,
    output logic         p_bit,
    output logic [N-1:0] sum_q,
    output logic [N-1:0] cry_q,
    output logic         busy
);
    import rbm_pkg::*;

    // Active path: inputs gated by the row select (operand isolation).
    logic [N-1:0] pp_d, hs_d, hc_d, s_d, co_d;
    assign pp_d = mcand  & {N{sel}};
    assign hs_d = sum_in & {N{sel}};
    assign hc_d = cry_in & {N{sel}};
    assign busy = (|pp_d) | (|hs_d) | (|hc_d);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_cell
            if (HALF) begin : g_ha
                assign s_d[i]  = pp_d[i] ^ hs_d[i] ^ hc_d[i];
                assign co_d[i] = (pp_d[i] & hs_d[i]) | (hc_d[i] & (pp_d[i] ^ hs_d[i]));
            end else begin : g_fa
                assign s_d[i]  = fa_sum(pp_d[i], hs_d[i], hc_d[i]);
                assign co_d[i] = fa_cout(pp_d[i], hs_d[i], hc_d[i]);
            end
        end
    endgenerate

    // Skip path: inputs gated by the inverted select.
    logic [N-1:0] bs_d, bc_d, byp_sum_d;
    logic [N-2:0] inc_c_d;
    logic         fix_p_d;
    assign bs_d       = sum_in & {N{~sel}};
    assign bc_d       = cry_in & {N{~sel}};
    assign fix_p_d    = bs_d[0] ^ bc_d[0];
    assign inc_c_d[0] = bs_d[0] & bc_d[0];

    generate
        for (i = 0; i < N - 1; i++) begin : g_inc
            assign byp_sum_d[i] = bs_d[i+1] ^ inc_c_d[i];
            if (i < N - 2) begin : g_chain
                assign inc_c_d[i+1] = bs_d[i+1] & inc_c_d[i];
            end
        end
    endgenerate
    assign byp_sum_d[N-1] = 1'b0;

    always_comb begin
        if (sel) begin
            p_bit = s_d[0];
            sum_q = {1'b0, s_d[N-1:1]};
            cry_q = co_d;
        end else begin
            p_bit = fix_p_d;
            sum_q = byp_sum_d;
            cry_q = {1'b0, bc_d[N-1:1]};
        end
    end
endmodule

// File: rtl/rbm_final_adder.sv
module rbm_final_adder #(
    parameter int N = 4
) (
    input  logic [N-1:0] sum_in,
    input  logic [N-1:0] cry_in,
    output logic [N-1:0] hi,
    output logic         cout
);
    import rbm_pkg::*;

    logic [N:0] c_d;
    assign c_d[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_rca
            assign hi[i]    = fa_sum(sum_in[i], cry_in[i], c_d[i]);
            assign c_d[i+1] = fa_cout(sum_in[i], cry_in[i], c_d[i]);
        end
    endgenerate
    assign cout = c_d[N];
endmodule

// File: rtl/bypass_array_mult.sv
module bypass_array_mult #(
    parameter int N = 4
) (
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [2*N-1:0] prod
);
    logic [N-1:0] sum_v [N];
    logic [N-1:0] cry_v [N];
    logic [N-1:0] lo_bits;
    logic [N-1:0] hi_bits;
    logic [N-1:0] row_busy;
    logic         fin_co;

    rbm_first_row #(.N(N)) u_row0 (
        .mcand (mcand),
        .mbit  (mplier[0]),
        .p_bit (lo_bits[0]),
        .sum_q (sum_v[0]),
        .cry_q (cry_v[0])
    );
    assign row_busy[0] = 1'b0;

    genvar j;
    generate
        for (j = 1; j < N; j++) begin : g_row
            rbm_csa_row #(.N(N), .HALF(j == 1)) u_row (
                .mcand  (mcand),
                .sel    (mplier[j]),
                .sum_in (sum_v[j-1]),
                .cry_in (cry_v[j-1]),
                .p_bit  (lo_bits[j]),
                .sum_q  (sum_v[j]),
                .cry_q  (cry_v[j]),
                .busy   (row_busy[j])
            );
        end
    endgenerate

    rbm_final_adder #(.N(N)) u_merge (
        .sum_in (sum_v[N-1]),
        .cry_in (cry_v[N-1]),
        .hi     (hi_bits),
        .cout   (fin_co)
    );

    assign prod = {hi_bits, lo_bits};
endmodule

// File: rtl/rbm_checker.sv
module rbm_checker #(
    parameter int N = 4
) (
    input logic [N-1:0]   mcand,
    input logic [N-1:0]   mplier,
    input logic [2*N-1:0] prod,
    input logic [N-1:0]   row_busy,
    input logic           fin_co
);
    logic [2*N-1:0] ref_d;
    assign ref_d = {{N{1'b0}}, mcand} * {{N{1'b0}}, mplier};

    always_comb begin
        a_r1_exact_product: assert (prod == ref_d);
        a_r1_no_merge_carry: assert (!fin_co);
        if (mcand == '0 || mplier == '0) begin
            a_r2_zero_operand: assert (prod == '0);
        end
        if (mplier == N'(1)) begin
            a_r3_unit_multiplier: assert (prod == {{N{1'b0}}, mcand});
        end
        a_r7_lsb_and: assert (prod[0] == (mcand[0] & mplier[0]));
        for (int j = 1; j < N; j++) begin
            if (!mplier[j]) begin
                a_r5_idle_row_isolated: assert (!row_busy[j]);
            end
        end
    end
endmodule

bind bypass_array_mult rbm_checker #(.N(N)) u_chk (
    .mcand    (mcand),
    .mplier   (mplier),
    .prod     (prod),
    .row_busy (row_busy),
    .fin_co   (fin_co)
);

// File: tb/tb_bypass_array_mult.sv
module tb_bypass_array_mult;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int compared   = 0;
    int mismatched = 0;
    int cycles     = 0;
    bit done       = 1'b0;

    logic [3:0]  a4, b4;
    logic [7:0]  p4;
    logic [5:0]  a6, b6;
    logic [11:0] p6;
    logic [7:0]  a8, b8;
    logic [15:0] p8;

    bypass_array_mult #(.N(4)) dut  (.mcand(a4), .mplier(b4), .prod(p4));
    bypass_array_mult #(.N(6)) dut6 (.mcand(a6), .mplier(b6), .prod(p6));
    bypass_array_mult #(.N(8)) dut8 (.mcand(a8), .mplier(b8), .prod(p8));

    // {multiplicand, multiplier, expected product} for N=4
    localparam logic [15:0] VEC [14] = '{
        {4'd3,  4'd5,  8'd15},  {4'd15, 4'd15, 8'd225}, {4'd9,  4'd0,  8'd0},
        {4'd0,  4'd13, 8'd0},   {4'd7,  4'd1,  8'd7},   {4'd11, 4'd10, 8'd110},
        {4'd13, 4'd5,  8'd65},  {4'd15, 4'd10, 8'd150}, {4'd6,  4'd9,  8'd54},
        {4'd1,  4'd15, 8'd15},  {4'd15, 4'd8,  8'd120}, {4'd12, 4'd12, 8'd144},
        {4'd15, 4'd5,  8'd75},  {4'd14, 4'd6,  8'd84}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive4(input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        a4 = a; b4 = b;
        #1;
    endtask

    initial begin
        while (!done && cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got %0d expected %0d", cycles, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        a4 = '0; b4 = '0; a6 = '0; b6 = '0; a8 = '0; b8 = '0;
        #1;
        chk("R2 idle inputs N4", 16'(p4), 16'd0);
        chk("R2 idle inputs N8", p8, 16'd0);

        // Vector table walk: R1/R4/R6
        for (int k = 0; k < 14; k++) begin
            drive4(VEC[k][15:12], VEC[k][11:8]);
            chk("R1 table", 16'(p4), 16'(VEC[k][7:0]));
        end

        // R8: change inputs between edges, no clock edge before sampling
        @(posedge clk);
        #0.5;
        a4 = 4'd13; b4 = 4'd11;
        #0.5;
        chk("R8 comb update", 16'(p4), 16'd143);
        a4 = 4'd2;
        #0.5;
        chk("R8 comb update", 16'(p4), 16'd22);

        // Directed corner cases
        drive4(4'd15, 4'd0);  chk("R2 zero multiplier", 16'(p4), 16'd0);
        drive4(4'd0,  4'd15); chk("R2 zero multiplicand", 16'(p4), 16'd0);
        drive4(4'd11, 4'd1);  chk("R3 unit multiplier", 16'(p4), 16'd11);
        drive4(4'd15, 4'd15); chk("R4 all rows active", 16'(p4), 16'd225);
        drive4(4'd9,  4'd15); chk("R4 all rows active", 16'(p4), 16'd135);
        drive4(4'd15, 4'd5);  chk("R6 alternating 0101", 16'(p4), 16'd75);
        drive4(4'd15, 4'd10); chk("R6 alternating 1010", 16'(p4), 16'd150);
        drive4(4'd15, 4'd9);  chk("R6 skip pair 1001", 16'(p4), 16'd135);
        drive4(4'd5,  4'd3);  chk("R7 lsb", 16'(p4[0]), 16'd1);
        drive4(4'd5,  4'd2);  chk("R7 lsb", 16'(p4[0]), 16'd0);

        // R1 exhaustive at N=4
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                a4 = 4'(x); b4 = 4'(y);
                #1;
                chk("R1 sweep N4", 16'(p4), 16'(x * y));
            end
        end

        // R9 exhaustive at N=6
        for (int x = 0; x < 64; x++) begin
            for (int y = 0; y < 64; y++) begin
                a6 = 6'(x); b6 = 6'(y);
                #1;
                chk("R9 sweep N6", 16'(p6), 16'(x * y));
            end
        end

        // R9 corners and random pairs at N=8
        a8 = 8'd255; b8 = 8'd255; #1;
        chk("R9 N8 max", p8, 16'd65025);
        a8 = 8'd255; b8 = 8'b10101010; #1;
        chk("R6 N8 alternating", p8, 16'(255 * 170));
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] ra, rb;
            ra = 8'($urandom);
            rb = 8'($urandom);
            a8 = ra; b8 = rb;
            #1;
            chk("R9 random N8", p8, 16'(ra) * 16'(rb));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule